// File: doc/BRIEF.md
# Edge-Coded Isolated Logic Channel Set

This block models, at the digital level, a five-line one-way logic link between a system side and a field side. The compile-time parameter `N_S2F` (0 to 5) fixes the direction of each line: lines below `N_S2F` carry system pins to field outputs and the remaining lines carry field pins to system outputs. All six splits come from the same RTL.

Levels do not cross the barrier as levels. Each transmit lane turns a captured edge into a set-high or set-low event. Events pass through a registered barrier pipeline and reach a receive latch that changes only when an event arrives. A shared background timer resends the present level of every lane on a fixed interval, so a receiver that missed an edge is put right. Each side has an enable. Dropping it floats the outputs on that side, modelled as a per-pin output-enable, and freezes the inputs on that side at their last captured value. Raising it again sends the present level across. After reset a power-up hold keeps every output floating for a set number of cycles.

Top module: `iso_link`

## Requirements
- R1: Line i (0 to 4) carries `sys_pin_in[i]` to `fld_pin_out[i]` when i < N_S2F, and otherwise carries `fld_pin_in[i]` to `sys_pin_out[i]`. A pin position used as an input always drives output-enable 0 and data 0 on that side.
- R2: With both enables high and the power-up hold over, a change on a source pin appears at the destination output on exactly the BARRIER_STAGES+3rd rising edge, counting the edge that first samples the new level as the first. It never appears sooner.
- R3: The background timer resends the captured level of every lane once every REFRESH_CYC cycles after the power-up hold ends. An input held high through reset produces no edge event, so its output reads 0 right after the hold. It reads 1 no later than REFRESH_CYC+BARRIER_STAGES+3 edges after the hold ends.
- R4: For the first POR_CYC rising edges after reset is released, every output-enable on both sides is 0.
- R5: While a side's enable is low, every output-enable on that side is 0. The receive latches behind those outputs keep following their inputs, so the correct value shows on the first cycle after the enable returns.
- R6: While a side's enable is low, that side's input pins are ignored. The outputs they feed on the other side hold their value, including across refresh periods.
- R7: When a side's enable rises, the present level of each input pin on that side reaches its destination output on the BARRIER_STAGES+3rd rising edge, counting the edge where the enable is first seen high.
- R8: A receive output changes only on the edge after a barrier event has reached its latch.
- R9: Reset is synchronous and active low. While it is held, every output data bit and every output-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset; starts the power-up hold when released |
| sys_en | input | 1 | System-side enable: floats system outputs and freezes system inputs when low |
| fld_en | input | 1 | Field-side enable: floats field outputs and freezes field inputs when low |
| sys_pin_in | input | 5 | System-side input pins; only positions below N_S2F are used |
| fld_pin_in | input | 5 | Field-side input pins; only positions N_S2F and up are used |
| sys_pin_out | output | 5 | System-side output data for lines N_S2F and up |
| sys_pin_oe | output | 5 | System-side output-enable; 0 means high impedance |
| fld_pin_out | output | 5 | Field-side output data for lines below N_S2F |
| fld_pin_oe | output | 5 | Field-side output-enable; 0 means high impedance |

## Verification
The bench builds all six direction splits at once and drives them from shared pins, so a mask slip at the direction boundary shows up as a wrong bit in one instance. Every one of the 32 system patterns, paired with its complement on the field side, is checked one edge before and exactly at the expected arrival edge. A pipeline one register short or long therefore fails on every pattern. Inputs are held high through reset, so an output that is right too early means edge events leak out of the power-up hold, and one that never comes right means the refresh is missing. The freeze and re-enable cases run across two refresh periods. An input that is not truly frozen, or a re-enable that does not resend the level, leaves a stale or premature value at a known edge.

// File: rtl/iso_link_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the isolated logic link.
// Assumes: one clock for both sides; lines are numbered 0..ISO_LINES-1.
package iso_link_pkg;

    // Number of logic lines in the link.
    localparam int unsigned ISO_LINES = 5;

    // One event crossing the barrier: valid marks a set event, level is its value.
    typedef struct packed {
        logic valid;
        logic level;
    } iso_evt_t;

endpackage

// File: rtl/iso_timebase.sv
`timescale 1ns/1ps
// Power-up hold and background refresh timing for the whole link.
// After reset release, por_done rises on edge POR_CYC. From then on,
// refresh_tick is high for one cycle every REFRESH_CYC cycles.
// Assumes POR_CYC >= 1 and REFRESH_CYC >= 1.
module iso_timebase #(
    parameter int unsigned POR_CYC     = 7500,
    parameter int unsigned REFRESH_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    output logic por_done,
    output logic refresh_tick
);
    localparam int unsigned PW = $clog2(POR_CYC + 1);
    localparam int unsigned RW = $clog2(REFRESH_CYC + 1);
    localparam logic [PW-1:0] POR_LAST = PW'(POR_CYC - 1);
    localparam logic [RW-1:0] REF_LAST = RW'(REFRESH_CYC - 1);

    logic [PW-1:0] por_cnt;
    logic [RW-1:0] ref_cnt;

    // Count cycles of the power-up hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         por_cnt <= '0;
        else if (!por_done) por_cnt <= por_cnt + 1'b1;
    end

    // End the hold once the last hold cycle has been counted.
    always_ff @(posedge clk) begin
        if (!rst_n)                  por_done <= 1'b0;
        else if (por_cnt == POR_LAST) por_done <= 1'b1;
    end

    // Free-running refresh period counter, active only after the hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        ref_cnt <= '0;
        else if (por_done) ref_cnt <= (ref_cnt == REF_LAST) ? '0 : ref_cnt + 1'b1;
    end

    // Broadcast one refresh request at the end of each period.
    always_comb refresh_tick = por_done && (ref_cnt == REF_LAST);

endmodule

// File: rtl/iso_tx_lane.sv
`timescale 1ns/1ps
// Transmit side of one line. Captures the pin while the side is enabled
// and holds it otherwise. Emits a set event on a captured edge, on the
// cycle after the enable rises, or on a refresh request. An edge wins
// over the other two. No event leaves before the power-up hold ends.
module iso_tx_lane
    import iso_link_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin,
    input  logic     side_en,
    input  logic     active,
    input  logic     refresh_tick,
    output logic     cap_o,
    output iso_evt_t evt
);
    logic     cap;
    logic     prev;
    logic     en_q;
    logic     resync_q;
    iso_evt_t nxt;

    // Sample the pin only while this side is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap <= 1'b0;
        else if (side_en) cap <= pin;
    end

    // Keep the prior captured level and the prior enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev     <= 1'b0;
            en_q     <= 1'b0;
            resync_q <= 1'b0;
        end else begin
            prev     <= cap;
            en_q     <= side_en;
            resync_q <= side_en & ~en_q;
        end
    end

    // Choose the event for this cycle: edge first, then resync or refresh.
    always_comb begin
        nxt = '0;
        if (active) begin
            if (cap != prev) begin
                nxt.valid = 1'b1;
                nxt.level = cap;
            end else if (resync_q || refresh_tick) begin
                nxt.valid = 1'b1;
                nxt.level = cap;
            end
        end
    end

    // Register the event as it enters the barrier.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= '0;
        else        evt <= nxt;
    end

    assign cap_o = cap;

endmodule

// File: rtl/iso_barrier_pipe.sv
`timescale 1ns/1ps
// Fixed-latency carrier for events crossing the modelled barrier.
// STAGES registers; STAGES = 0 gives a plain wire.
module iso_barrier_pipe
    import iso_link_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  iso_evt_t din,
    output iso_evt_t dout
);
    generate
        if (STAGES == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            iso_evt_t stg [STAGES];

            // First stage takes the lane event.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= din;
            end

            for (genvar s = 1; s < STAGES; s++) begin : g_stage
                // Each later stage shifts the previous one on.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end

            assign dout = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/iso_rx_latch.sv
`timescale 1ns/1ps
// Receive side of one line: a held output that only set events change.
module iso_rx_latch
    import iso_link_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  iso_evt_t evt,
    output logic     q
);
    // Update the held value on a set event; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)         q <= 1'b0;
        else if (evt.valid) q <= evt.level;
    end

endmodule

// File: rtl/iso_link.sv
`timescale 1ns/1ps
// Five-line isolated logic link. N_S2F picks how many low-numbered lines
// run system to field; the rest run field to system. Each line is a tx
// lane, a barrier pipe and an rx latch. A destination pin drives only
// when its side is enabled and the power-up hold is over.
// Assumes 0 <= N_S2F <= 5 and a single shared clock.
module iso_link
    import iso_link_pkg::*;
#(
    parameter int unsigned CLK_MHZ        = 250,
    parameter int unsigned N_S2F          = 2,
    parameter int unsigned BARRIER_STAGES = 2,
    parameter int unsigned REFRESH_CYC    = CLK_MHZ * 5,
    parameter int unsigned POR_CYC        = CLK_MHZ * 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sys_en,
    input  logic       fld_en,
    input  logic [4:0] sys_pin_in,
    input  logic [4:0] fld_pin_in,
    output logic [4:0] sys_pin_out,
    output logic [4:0] sys_pin_oe,
    output logic [4:0] fld_pin_out,
    output logic [4:0] fld_pin_oe
);
    localparam int unsigned NL = ISO_LINES;

    logic          por_done;
    logic          refresh_tick;
    logic [NL-1:0] tx_cap_vec;
    logic [NL-1:0] rx_hit_vec;

    iso_timebase #(
        .POR_CYC     (POR_CYC),
        .REFRESH_CYC (REFRESH_CYC)
    ) u_timebase (
        .clk          (clk),
        .rst_n        (rst_n),
        .por_done     (por_done),
        .refresh_tick (refresh_tick)
    );

    generate
        for (genvar i = 0; i < NL; i++) begin : g_line
            logic     src_pin;
            logic     src_en;
            logic     rx_q;
            iso_evt_t tx_evt;
            iso_evt_t rx_evt;

            if (i < N_S2F) begin : g_s2f
                assign src_pin        = sys_pin_in[i];
                assign src_en         = sys_en;
                assign fld_pin_out[i] = rx_q;
                assign fld_pin_oe[i]  = fld_en & por_done;
                assign sys_pin_out[i] = 1'b0;
                assign sys_pin_oe[i]  = 1'b0;
            end else begin : g_f2s
                assign src_pin        = fld_pin_in[i];
                assign src_en         = fld_en;
                assign sys_pin_out[i] = rx_q;
                assign sys_pin_oe[i]  = sys_en & por_done;
                assign fld_pin_out[i] = 1'b0;
                assign fld_pin_oe[i]  = 1'b0;
            end

            iso_tx_lane u_tx (
                .clk          (clk),
                .rst_n        (rst_n),
                .pin          (src_pin),
                .side_en      (src_en),
                .active       (por_done),
                .refresh_tick (refresh_tick),
                .cap_o        (tx_cap_vec[i]),
                .evt          (tx_evt)
            );

            iso_barrier_pipe #(
                .STAGES (BARRIER_STAGES)
            ) u_pipe (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (tx_evt),
                .dout  (rx_evt)
            );

            iso_rx_latch u_rx (
                .clk   (clk),
                .rst_n (rst_n),
                .evt   (rx_evt),
                .q     (rx_q)
            );

            assign rx_hit_vec[i] = rx_evt.valid;
        end
    endgenerate

endmodule

// File: rtl/iso_link_chk.sv
`timescale 1ns/1ps
// Property checker for iso_link, attached by bind below.
module iso_link_chk #(
    parameter int unsigned N_S2F   = 2,
    parameter int unsigned POR_CYC = 7500
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sys_en,
    input logic       fld_en,
    input logic [4:0] sys_pin_out,
    input logic [4:0] sys_pin_oe,
    input logic [4:0] fld_pin_out,
    input logic [4:0] fld_pin_oe,
    input logic [4:0] tx_cap,
    input logic [4:0] rx_hit
);
    localparam int unsigned CW = $clog2(POR_CYC + 2);
    localparam logic [CW-1:0] SAT  = CW'(POR_CYC + 1);
    localparam logic [CW-1:0] HOLD = CW'(POR_CYC);

    logic [CW-1:0] since_rst;

    // Count edges since reset release, saturating past the hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != SAT) since_rst <= since_rst + 1'b1;
    end

    // R4
    por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < HOLD) |-> (sys_pin_oe == 5'b0 && fld_pin_oe == 5'b0));

    generate
        for (genvar i = 0; i < 5; i++) begin : g_ln
            if (i < N_S2F) begin : g_s2f
                // R1
                dir_s2f_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (sys_pin_oe[i] == 1'b0 && sys_pin_out[i] == 1'b0));
                // R5
                dst_off_s2f_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    !fld_en |-> !fld_pin_oe[i]);
                // R6
                freeze_s2f_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    !$past(sys_en) |-> $stable(tx_cap[i]));
                // R8
                hold_s2f_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    !$stable(fld_pin_out[i]) |-> $past(rx_hit[i]));
            end else begin : g_f2s
                // R1
                dir_f2s_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (fld_pin_oe[i] == 1'b0 && fld_pin_out[i] == 1'b0));
                // R5
                dst_off_f2s_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    !sys_en |-> !sys_pin_oe[i]);
                // R6
                freeze_f2s_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    !$past(fld_en) |-> $stable(tx_cap[i]));
                // R8
                hold_f2s_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    !$stable(sys_pin_out[i]) |-> $past(rx_hit[i]));
            end
        end
    endgenerate

endmodule

bind iso_link iso_link_chk #(
    .N_S2F   (N_S2F),
    .POR_CYC (POR_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_en      (sys_en),
    .fld_en      (fld_en),
    .sys_pin_out (sys_pin_out),
    .sys_pin_oe  (sys_pin_oe),
    .fld_pin_out (fld_pin_out),
    .fld_pin_oe  (fld_pin_oe),
    .tx_cap      (tx_cap_vec),
    .rx_hit      (rx_hit_vec)
);

// File: tb/test_iso_link.sv
`timescale 1ns/1ps
// Sweeps all six direction splits side by side from shared pins.
module test_iso_link;
    localparam int S = 2;
    localparam int R = 40;
    localparam int P = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_en = 1'b1;
    logic fld_en = 1'b1;
    logic [4:0] sys_in = 5'h1F;
    logic [4:0] fld_in = 5'h1F;
    logic [4:0] so  [6];
    logic [4:0] soe [6];
    logic [4:0] fo  [6];
    logic [4:0] foe [6];

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    generate
        for (genvar c = 0; c < 6; c++) begin : g_cfg
            iso_link #(
                .N_S2F          (c),
                .BARRIER_STAGES (S),
                .REFRESH_CYC    (R),
                .POR_CYC        (P)
            ) i_iso_link (
                .clk         (clk),
                .rst_n       (rst_n),
                .sys_en      (sys_en),
                .fld_en      (fld_en),
                .sys_pin_in  (sys_in),
                .fld_pin_in  (fld_in),
                .sys_pin_out (so[c]),
                .sys_pin_oe  (soe[c]),
                .fld_pin_out (fo[c]),
                .fld_pin_oe  (foe[c])
            );
        end
    endgenerate

    function automatic logic [4:0] msk(input int c);
        return 5'((1 << c) - 1);
    endfunction

    task automatic chk(input string what, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Compare every instance's data outputs with the given source levels.
    task automatic chk_data(input string req, input logic [4:0] s_lvl, input logic [4:0] f_lvl);
        for (int c = 0; c < 6; c++) begin
            chk($sformatf("%s cfg%0d fld_pin_out", req, c), fo[c], s_lvl & msk(c));
            chk($sformatf("%s cfg%0d sys_pin_out", req, c), so[c], f_lvl & ~msk(c));
        end
    endtask

    task automatic chk_oe(input string req, input logic f_on, input logic s_on);
        for (int c = 0; c < 6; c++) begin
            chk($sformatf("%s cfg%0d fld_pin_oe", req, c), foe[c], f_on ? msk(c) : 5'h00);
            chk($sformatf("%s cfg%0d sys_pin_oe", req, c), soe[c], s_on ? ~msk(c) : 5'h00);
        end
    endtask

    initial begin
        logic [4:0] old_s;
        logic [4:0] old_f;
        @(negedge clk);
        step(3);
        // R9: reset holds everything low
        chk_data("R9", 5'h00, 5'h00);
        chk_oe("R9", 1'b0, 1'b0);
        rst_n = 1'b1;
        step(10);
        // R4: hold keeps outputs floating
        chk_oe("R4", 1'b0, 1'b0);
        step(P + 2 - 10);
        // R1: direction split of output-enables after the hold
        chk_oe("R1", 1'b1, 1'b1);
        // R3: no edge was seen, so nothing has crossed before the first refresh
        chk_data("R3 pre-refresh", 5'h00, 5'h00);
        step(R + S + 4 - 2);
        // R3: refresh has carried the held-high inputs across
        chk_data("R3", 5'h1F, 5'h1F);

        // R2: exhaustive pattern sweep with exact arrival edge
        old_s = 5'h1F;
        old_f = 5'h1F;
        for (int v = 0; v < 32; v++) begin
            sys_in = 5'(v);
            fld_in = ~5'(v);
            step(S + 2);
            chk_data("R2 early", old_s, old_f);
            step(1);
            chk_data("R2", sys_in, fld_in);
            old_s = sys_in;
            old_f = fld_in;
        end

        // R5: field outputs float, latches keep following
        fld_en = 1'b0;
        step(1);
        chk_oe("R5 fld off", 1'b0, 1'b1);
        sys_in = 5'h0A;
        step(S + 4);
        fld_en = 1'b1;
        step(1);
        chk_oe("R5 fld back", 1'b1, 1'b1);
        chk_data("R5", 5'h0A, old_f);

        // R6: system inputs frozen while system side is off
        sys_en = 1'b0;
        step(1);
        sys_in = 5'h15;
        step(2 * R + 8);
        chk_data("R6 R8 sys frozen", 5'h0A, old_f);
        chk_oe("R5 sys off", 1'b1, 1'b0);
        // R7: re-enable resends the present level at the exact edge
        sys_en = 1'b1;
        step(S + 2);
        chk_data("R7 early", 5'h0A, old_f);
        step(1);
        chk_data("R7 sys", 5'h15, old_f);

        // R6: field inputs frozen while field side is off
        fld_en = 1'b0;
        step(1);
        fld_in = 5'h0B;
        step(2 * R + 8);
        chk_data("R6 fld frozen", 5'h15, old_f);
        fld_en = 1'b1;
        step(S + 3);
        chk_data("R7 fld", 5'h15, 5'h0B);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule